// File: doc/BRIEF.md
# Serial-Loaded 12-Bit Converter Front End

This block is the digital input stage of a serial-loaded 12-bit converter. A host writes 16-bit frames over three wires: an active-low select, a serial clock and a data line. Each frame is sent MSB first. It starts with four fill bits and ends with the 12-bit code. The bits pass through a 16-stage shift chain. When the select line returns high, the low 12 bits of the chain are copied into the converter code register. At the same moment a single-cycle update strobe tells the analog side that a new code is ready.

The oldest bit of the chain drives a serial output. The output changes only on the falling serial clock edge, and only while the block is selected. It keeps its level while the block is deselected. Because of this, several blocks can be cascaded by wiring each serial output to the next block's data input. N blocks are then loaded with 16×N clocks inside one select window.

The serial clock, select and data inputs are sampled by a system clock that runs at least four times faster than the serial clock. Two of the inputs act without that clock:
- an active-low clear forces the code register to zero at once;
- the active-low reset also forces it to zero.

Top module: `serdac_front`

## Requirements
- R1: While reset is low, and right after it, `code_o` is 0x000, `sdo_o` is 0 and `upd_o` is 0. No update strobe is produced by reset.
- R2: A frame is shifted MSB first, bit 15 first. When select rises, `code_o` takes shift-chain bits 11..0, which are the last 12 bits sent. The four fill bits (15..12) never reach `code_o`.
- R3: Bits are taken only on rising serial clock edges while select is low. Serial clock activity while select is high leaves the shift chain unchanged, which a later zero-clock frame can show.
- R4: `sdo_o` changes only after a falling serial clock edge with select low, and then shows chain bit 15. When sampled before each rising edge of a frame, `sdo_o` reproduces the previous 16 bits, in order.
- R5: While select is high, `sdo_o` holds the last bit it drove, even when the serial clock toggles. It is never high-impedance.
- R6: A frame shorter than 16 clocks is not rejected. On the select rising edge, bits 11..0 of the chain are loaded exactly as they stand.
- R7: Driving `clr_ni` low sets `code_o` to 0x000 at once, with no system clock edge needed and whatever the state of select. The shift chain is not disturbed by clear.
- R8: If `clr_ni` is low at the select rising edge, `code_o` stays 0x000 and no update strobe is given. The code is not loaded later when clear is released.
- R9: `upd_o` is high for exactly one system clock per load of the code register. It is never high because of clear or reset.
- R10: When two blocks are chained (the first block's `sdo_o` feeds the second block's `sdi_i`, with a shared select and serial clock), a 32-clock frame leaves the first 16 bits sent in the far block and the last 16 bits in the near block.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, at least 4x the serial clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Serial select, active low |
| sclk_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data in |
| clr_ni | input | 1 | Asynchronous active-low clear of the code register |
| sdo_o | output | 1 | Serial data out for cascading |
| code_o | output | CODE_W | Converter code register |
| upd_o | output | 1 | One-cycle strobe when the code register is loaded |

## Verification
The hardest case to reach from the ports is proving that the shift chain keeps its contents while it is hidden behind a zero or cleared `code_o`. The chain itself is not visible, so the bench brings it out through the normal interface: it opens and closes select with no serial clocks at all, which reloads the chain's low 12 bits. The bench uses this zero-clock frame in three places:
- after serial clock activity while deselected;
- after a clear pulse;
- after a short 4-clock frame, whose expected value is the previous frame shifted left by four.

A second chained instance shows that the serial output timing is enough to feed a downstream block.

// File: rtl/serdac_pkg.sv
package serdac_pkg;
  typedef struct packed {
    logic shift;  // rising sclk while selected
    logic step;   // falling sclk while selected
    logic load;   // select released
    logic sel;    // select active (synchronized)
  } strobe_t;
endpackage

// File: rtl/serdac_sync.sv
module serdac_sync #(
  parameter int unsigned WIDTH = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[g] <= RST_VAL;
      else if (g == 0) stage_q[g] <= d_i;
      else stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/serdac_edges.sv
module serdac_edges
  import serdac_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    sclk_s_i,
  input  logic    cs_s_i,
  output strobe_t strb_o
);
  logic sclk_q, cs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
    end else begin
      sclk_q <= sclk_s_i;
      cs_q   <= cs_s_i;
    end
  end

  always_comb begin
    strb_o.sel   = ~cs_s_i;
    strb_o.shift = sclk_s_i & ~sclk_q & ~cs_s_i;
    strb_o.step  = ~sclk_s_i & sclk_q & ~cs_s_i;
    strb_o.load  = cs_s_i & ~cs_q;
  end
endmodule

// File: rtl/serdac_shift.sv
module serdac_shift #(
  parameter int unsigned FRAME_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               shift_i,
  input  logic               step_i,
  input  logic               sdi_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic               sdo_o
);
  logic [FRAME_W-1:0] frame_q;
  logic               sdo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q <= '0;
      sdo_q   <= 1'b0;
    end else begin
      if (shift_i) frame_q <= {frame_q[FRAME_W-2:0], sdi_i};
      // output advances half a serial period after the shift
      if (step_i) sdo_q <= frame_q[FRAME_W-1];
    end
  end

  assign frame_o = frame_q;
  assign sdo_o   = sdo_q;
endmodule

// File: rtl/serdac_code.sv
module serdac_code #(
  parameter int unsigned CODE_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_ni,
  input  logic              load_i,
  input  logic [CODE_W-1:0] data_i,
  output logic [CODE_W-1:0] code_o,
  output logic              upd_o
);
  logic              wipe_n;
  logic [CODE_W-1:0] code_q;
  logic              upd_q;

  assign wipe_n = rst_ni & clr_ni;

  always_ff @(posedge clk_i or negedge wipe_n) begin
    if (!wipe_n) code_q <= '0;
    else if (load_i) code_q <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) upd_q <= 1'b0;
    else upd_q <= load_i & clr_ni;
  end

  assign code_o = code_q;
  assign upd_o  = upd_q;
endmodule

// File: rtl/serdac_front.sv
module serdac_front
  import serdac_pkg::*;
#(
  parameter int unsigned FRAME_W = 16,
  parameter int unsigned CODE_W = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic              sdi_i,
  input  logic              clr_ni,
  output logic              sdo_o,
  output logic [CODE_W-1:0] code_o,
  output logic              upd_o
);
  localparam int FILL_W = int'(FRAME_W) - int'(CODE_W);

  if (FILL_W < 0) begin : g_bad_cfg
    $error("CODE_W must not exceed FRAME_W");
  end

  logic [2:0]         pins_raw, pins_s;
  strobe_t            strb;
  logic [FRAME_W-1:0] frame_q;

  assign pins_raw = {sdi_i, cs_ni, sclk_i};

  serdac_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b010)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pins_raw),
    .q_o   (pins_s)
  );

  serdac_edges u_edges (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sclk_s_i(pins_s[0]),
    .cs_s_i  (pins_s[1]),
    .strb_o  (strb)
  );

  serdac_shift #(.FRAME_W(FRAME_W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .shift_i(strb.shift),
    .step_i (strb.step),
    .sdi_i  (pins_s[2]),
    .frame_o(frame_q),
    .sdo_o  (sdo_o)
  );

  serdac_code #(.CODE_W(CODE_W)) u_code (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_ni(clr_ni),
    .load_i(strb.load),
    .data_i(frame_q[CODE_W-1:0]),
    .code_o(code_o),
    .upd_o (upd_o)
  );
endmodule

// File: rtl/serdac_front_chk.sv
module serdac_front_chk
  import serdac_pkg::*;
#(
  parameter int unsigned FRAME_W = 16,
  parameter int unsigned CODE_W = 12
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               clr_ni,
  input logic               sdo_o,
  input logic [CODE_W-1:0]  code_o,
  input logic               upd_o,
  input strobe_t            strb_i,
  input logic [FRAME_W-1:0] frame_i
);
  p_clear_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_ni |-> code_o == '0);

  p_upd_from_load_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o |-> $past(strb_i.load));

  p_upd_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o |=> !upd_o);

  p_code_moves_on_upd_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ni && $past(clr_ni) && !$stable(code_o)) |-> upd_o);

  p_no_shift_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strb_i.sel |=> $stable(frame_i));

  p_sdo_hold_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strb_i.sel |=> $stable(sdo_o));

  p_sdo_on_fall_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sdo_o) |-> $past(strb_i.step));
endmodule

bind serdac_front serdac_front_chk #(.FRAME_W(FRAME_W), .CODE_W(CODE_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .clr_ni (clr_ni),
  .sdo_o  (sdo_o),
  .code_o (code_o),
  .upd_o  (upd_o),
  .strb_i (strb),
  .frame_i(frame_q)
);

// File: tb/serdac_front_tb.sv
module serdac_front_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // {frame, expected code}
  localparam logic [27:0] VEC [NVEC] = '{
    {16'h0ABC, 12'hABC}, {16'hFFFF, 12'hFFF}, {16'h0000, 12'h000},
    {16'h5A5A, 12'hA5A}, {16'hF001, 12'h001}, {16'h93C5, 12'h3C5}
  };

  logic clk = 1'b0;
  logic rst_n, cs_n, sclk, sdi, clr_n;
  logic sdo, sdo2, upd, upd2;
  logic [11:0] code, code2;
  int n_tests = 0, n_fail = 0, upd_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serdac_front u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk), .sdi_i(sdi),
    .clr_ni(clr_n), .sdo_o(sdo), .code_o(code), .upd_o(upd)
  );

  // downstream stage of a two-block cascade
  serdac_front u_dut2 (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk), .sdi_i(sdo),
    .clr_ni(1'b1), .sdo_o(sdo2), .code_o(code2), .upd_o(upd2)
  );

  always @(posedge clk) if (upd === 1'b1) upd_cnt++;

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b, output logic seen);
    sdi = b;
    waitn(4);
    seen = sdo;
    sclk = 1'b1;
    waitn(4);
    sclk = 1'b0;
    waitn(4);
  endtask

  task automatic send_word(input logic [15:0] w, output logic [15:0] cap);
    for (int k = 15; k >= 0; k--) send_bit(w[k], cap[k]);
  endtask

  task automatic open_frame();
    cs_n = 1'b0;
    waitn(4);
  endtask

  task automatic close_frame();
    cs_n = 1'b1;
    waitn(8);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] cap, prev;
    logic s, sdo_before;
    int base;
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; sdi = 1'b0; clr_n = 1'b1;
    waitn(3);
    chk("R1 code in reset", code, 0);
    chk("R1 sdo in reset", sdo, 0);
    chk("R1 upd in reset", upd, 0);
    rst_n = 1'b1;
    waitn(4);
    chk("R1 code after reset", code, 0);
    chk("R9 no strobe from reset", upd_cnt, 0);

    // table-driven frames
    prev = '0;
    for (int i = 0; i < NVEC; i++) begin
      base = upd_cnt;
      open_frame();
      send_word(VEC[i][27:12], cap);
      close_frame();
      chk($sformatf("R2 code vec%0d", i), code, VEC[i][11:0]);
      chk($sformatf("R4 sdo stream vec%0d", i), cap, prev);
      chk($sformatf("R9 one strobe vec%0d", i), upd_cnt - base, 1);
      chk($sformatf("R5 sdo hold vec%0d", i), sdo, VEC[i][27]);
      prev = VEC[i][27:12];
    end

    // short frame: chain now 0x93C5, four more bits 1010
    base = upd_cnt;
    open_frame();
    send_bit(1'b1, s); send_bit(1'b0, s); send_bit(1'b1, s); send_bit(1'b0, s);
    close_frame();
    chk("R6 short frame code", code, 12'hC5A);
    chk("R6 short frame strobe", upd_cnt - base, 1);

    // serial clock while deselected
    sdo_before = sdo;
    sdi = 1'b1;
    for (int k = 0; k < 5; k++) begin
      sclk = 1'b1; waitn(4); sclk = 1'b0; waitn(4);
    end
    chk("R5 sdo held while deselected", sdo, sdo_before);
    chk("R3 code unchanged", code, 12'hC5A);
    open_frame();
    close_frame();
    chk("R3 chain untouched while deselected", code, 12'hC5A);

    // asynchronous clear
    clr_n = 1'b0;
    #1;
    chk("R7 async clear", code, 0);
    waitn(2);
    clr_n = 1'b1;
    waitn(2);
    chk("R7 stays clear after release", code, 0);
    base = upd_cnt;
    open_frame();
    close_frame();
    chk("R7 chain kept across clear", code, 12'hC5A);
    chk("R9 strobe on reload", upd_cnt - base, 1);

    // clear held across select rise
    clr_n = 1'b0;
    waitn(1);
    base = upd_cnt;
    open_frame();
    close_frame();
    chk("R8 code held at zero", code, 0);
    chk("R8 R9 no strobe under clear", upd_cnt - base, 0);
    clr_n = 1'b1;
    waitn(4);
    chk("R8 no late load", code, 0);

    // two-block cascade, 32 clocks
    open_frame();
    send_word(16'h1234, cap);
    send_word(16'hFEDC, cap);
    close_frame();
    chk("R10 near block code", code, 12'hEDC);
    chk("R10 far block code", code2, 12'h234);

    rst_n = 1'b0;
    waitn(2);
    chk("R1 code after late reset", code, 0);
    chk("R1 sdo after late reset", sdo, 0);

    summary();
    $finish;
  end
endmodule